// File: doc/BRIEF.md
# Transfer Descriptor Outcome Updater

This block takes a single transfer descriptor from a host-side bus schedule engine. That engine is responsible for fetching the descriptor from memory and writing the result back. The descriptor arrives as a 32-bit control word and a 32-bit token word. From the token the block extracts the packet fields the bus side needs: packet identifier, device address, endpoint and maximum length. It then waits for the device side to report how the transaction ended. From that report it computes the rewritten control word, a two-bit interrupt-cause mask and a completion code. The schedule engine uses the completion code to decide whether to advance the queue, stay on it, or abandon the rest of the frame.

The control word keeps its bit meanings, because memory-resident software decodes them:
- bit 29 requests short-packet detection;
- bits 28:27 hold a retry counter;
- bit 25 selects isochronous handling;
- bit 24 requests an interrupt on completion;
- bit 23 marks the descriptor active;
- bit 22 is the stall flag;
- bit 20 is the babble flag;
- bit 19 is the NAK flag;
- bit 18 is the timeout flag;
- bits 10:0 hold the actual length minus one.

The token carries the packet identifier in bits 7:0, the device address in 14:8, the endpoint in 18:15, and the maximum length minus one in 31:21.

Both the descriptor and the device response enter through valid/ready handshakes. An active descriptor with a legal packet identifier produces a "pending" report first. The final report follows one cycle after the response handshake. The response can be held off for any number of cycles.

Top module: `td_outcome_updater`

## Requirements
- R1: After reset, td_ready is 1 and rsp_ready, pkt_valid, res_valid, res_perr and res_uerr are all 0.
- R2: A descriptor accepted with control bit 23 clear yields exactly one report in the next cycle. That report has code 1 (not advanced), the control word unchanged, and cause mask {0, ctrl[24]}. The block stays ready for the next descriptor and never requests a response.
- R3: While waiting for a response, pkt_valid is 1 and the packet fields are taken from the token as follows: pid = token[7:0], address = token[14:8], endpoint = token[18:15], maximum length = (token[31:21] + 1) mod 2048.
- R4: A descriptor that is active but whose packet identifier is none of IN (0x69), OUT (0xE1) or SETUP (0x2D) yields code 2 (abort frame) and a one-cycle res_perr. The control word is unchanged and the cause mask is {0, ctrl[24]}.
- R5: An active descriptor with a legal identifier first yields a report with code 3 (pending), the control word unchanged and cause 0. The block then holds rsp_ready at 1 and td_ready at 0 until a response is accepted. The final report follows one cycle after that acceptance.
- R6: A data response (kind 0) clears bits 23 and 19 and writes (len − 1) mod 2048 into bits 10:0. For OUT and SETUP, len is the maximum length. For IN, len is the reported byte count.
- R7: An IN data response longer than the maximum, or a babble response (kind 4), sets bits 20 and 22, clears bit 23, leaves bits 10:0 untouched, and gives code 2.
- R8: A successful IN with bit 29 set and a length below the maximum sets cause bit 1 and gives code 1. Every other successful data response gives code 0.
- R9: A no-device response (kind 3) or an unassigned kind (5 to 7) sets bit 18 and gives code 1. It also decrements bits 28:27 when they are nonzero. When the decrement reaches zero, bit 23 is cleared and res_uerr pulses. A counter already at zero stays at zero, with no error.
- R10: A NAK response (kind 1) sets bit 19 and gives code 1, leaving bit 23 alone. On a SETUP it is additionally handled as a timeout, as in R9.
- R11: A STALL response (kind 2) sets bit 22, clears bit 23 and gives code 1.
- R12: If bit 25 is set, every final report that follows a response has bit 23 cleared.
- R13: Cause bit 0 of every report other than pending equals control bit 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| td_valid | input | 1 | Descriptor offered |
| td_ready | output | 1 | Block can take a descriptor |
| td_ctrl | input | 32 | Descriptor control word |
| td_token | input | 32 | Descriptor token word |
| pkt_valid | output | 1 | Packet fields valid, response awaited |
| pkt_pid | output | 8 | Packet identifier |
| pkt_addr | output | 7 | Device address |
| pkt_ep | output | 4 | Endpoint number |
| pkt_maxlen | output | 11 | Maximum byte count |
| rsp_valid | input | 1 | Device response offered |
| rsp_ready | output | 1 | Block takes the response |
| rsp_kind | input | 3 | 0 data, 1 NAK, 2 STALL, 3 no device, 4 babble, 5-7 timeout |
| rsp_len | input | 12 | Byte count for a data response |
| res_valid | output | 1 | One-cycle report strobe |
| res_ctrl | output | 32 | Updated control word |
| res_code | output | 2 | 0 success, 1 not advanced, 2 abort frame, 3 pending |
| res_cause | output | 2 | Bit 0 completion interrupt, bit 1 short packet |
| res_perr | output | 1 | Protocol error strobe (bad identifier) |
| res_uerr | output | 1 | Bus error strobe (retries exhausted) |

## Verification
Directed descriptors each isolate one branch:
- inactive, bad identifier and OUT success;
- IN short with detection on, and IN over-length;
- timeouts with counter values 1 and 0;
- NAK on SETUP against NAK on IN, which separates the timeout fold-in from a plain NAK;
- STALL;
- isochronous select combined with a NAK, which shows the active clear overriding a result that would otherwise keep the descriptor live;
- a maximum-length field of all ones, which exercises the n−1 wrap to zero.

Random descriptors then mix every identifier class, counter value, flag bit, response kind and response delay. Lengths are drawn around the maximum, so the exact, short and over-length cases all occur and are told apart by the length field and the code.

// File: rtl/td_pkg.sv
package td_pkg;
  localparam int TD_WORD_W = 32;
  localparam int TD_LEN_W  = 11;
  localparam int TD_RLEN_W = TD_LEN_W + 1;
  localparam int TD_ERR_W  = 2;

  // control word bit positions (decoded by software, positions are fixed)
  localparam int B_SPD    = 29;
  localparam int B_ERRLO  = 27;
  localparam int B_ISO    = 25;
  localparam int B_IOC    = 24;
  localparam int B_ACT    = 23;
  localparam int B_STALL  = 22;
  localparam int B_BABBLE = 20;
  localparam int B_NAK    = 19;
  localparam int B_TMO    = 18;

  // token field positions
  localparam int T_ADDR_LO = 8;
  localparam int T_EP_LO   = 15;
  localparam int T_MAX_LO  = 21;

  localparam logic [7:0] PID_IN    = 8'h69;
  localparam logic [7:0] PID_OUT   = 8'hE1;
  localparam logic [7:0] PID_SETUP = 8'h2D;

  typedef enum logic [1:0] {
    CODE_SUCCESS = 2'd0,
    CODE_NOADV   = 2'd1,
    CODE_ABORT   = 2'd2,
    CODE_PENDING = 2'd3
  } td_code_e;

  localparam logic [2:0] RSP_DATA   = 3'd0;
  localparam logic [2:0] RSP_NAK    = 3'd1;
  localparam logic [2:0] RSP_STALL  = 3'd2;
  localparam logic [2:0] RSP_NODEV  = 3'd3;
  localparam logic [2:0] RSP_BABBLE = 3'd4;

  typedef enum logic [1:0] {PC_IN, PC_OUT, PC_SETUP, PC_BAD} pid_class_e;

  typedef struct packed {
    logic [7:0]          pid;
    logic [6:0]          addr;
    logic [3:0]          ep;
    logic [TD_LEN_W-1:0] maxlen;
    pid_class_e          cls;
  } tok_fields_t;
endpackage

// File: rtl/td_reset_sync.sv
module td_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/td_token_decode.sv
module td_token_decode
  import td_pkg::*;
#(
  parameter int WORD_W = TD_WORD_W,
  parameter int LEN_W  = TD_LEN_W
) (
  input  logic [WORD_W-1:0] token,
  output tok_fields_t       fields
);
  localparam int MAX_LO = WORD_W - LEN_W;

  logic [LEN_W-1:0] enc_len;

  always_comb begin
    enc_len       = token[MAX_LO +: LEN_W];
    fields.pid    = token[7:0];
    fields.addr   = token[T_ADDR_LO +: 7];
    fields.ep     = token[T_EP_LO +: 4];
    fields.maxlen = enc_len + 1'b1;   // n-1 encoding, wraps to zero
    case (token[7:0])
      PID_IN:    fields.cls = PC_IN;
      PID_OUT:   fields.cls = PC_OUT;
      PID_SETUP: fields.cls = PC_SETUP;
      default:   fields.cls = PC_BAD;
    endcase
  end
endmodule

// File: rtl/td_retry_step.sv
module td_retry_step #(
  parameter int ERR_W = 2
) (
  input  logic [ERR_W-1:0] cnt_in,
  output logic [ERR_W-1:0] cnt_out,
  output logic             exhausted
);
  localparam logic [ERR_W-1:0] ONE = ERR_W'(1);

  always_comb begin
    if (cnt_in == '0) begin
      cnt_out   = '0;
      exhausted = 1'b0;
    end else begin
      cnt_out   = cnt_in - ONE;
      exhausted = (cnt_in == ONE);
    end
  end
endmodule

// File: rtl/td_outcome_calc.sv
module td_outcome_calc
  import td_pkg::*;
#(
  parameter int WORD_W = TD_WORD_W,
  parameter int LEN_W  = TD_LEN_W,
  parameter int ERR_W  = TD_ERR_W
) (
  input  logic [WORD_W-1:0] ctrl,
  input  tok_fields_t       fields,
  input  logic [2:0]        kind,
  input  logic [LEN_W:0]    rsp_len,
  output logic [WORD_W-1:0] new_ctrl,
  output logic [1:0]        code,
  output logic              short_hit,
  output logic              bus_err
);
  logic [ERR_W-1:0] cnt_next;
  logic             cnt_done;
  logic             babble;
  logic             timeout;
  logic [LEN_W-1:0] eff_len;

  td_retry_step #(.ERR_W(ERR_W)) u_retry (
    .cnt_in    (ctrl[B_ERRLO +: ERR_W]),
    .cnt_out   (cnt_next),
    .exhausted (cnt_done)
  );

  // classify the device response
  always_comb begin
    babble  = 1'b0;
    timeout = 1'b0;
    eff_len = fields.maxlen;
    case (kind)
      RSP_DATA: begin
        if (fields.cls == PC_IN) begin
          if (rsp_len > {1'b0, fields.maxlen}) babble = 1'b1;
          else                                 eff_len = rsp_len[LEN_W-1:0];
        end
      end
      RSP_NAK:    timeout = (fields.cls == PC_SETUP);
      RSP_STALL:  timeout = 1'b0;
      RSP_BABBLE: babble  = 1'b1;
      default:    timeout = 1'b1;
    endcase
  end

  // rewrite the control word
  always_comb begin
    new_ctrl  = ctrl;
    code      = CODE_NOADV;
    short_hit = 1'b0;
    bus_err   = 1'b0;
    if (ctrl[B_ISO]) new_ctrl[B_ACT] = 1'b0;
    if (babble) begin
      new_ctrl[B_BABBLE] = 1'b1;
      new_ctrl[B_STALL]  = 1'b1;
      new_ctrl[B_ACT]    = 1'b0;
      code               = CODE_ABORT;
    end else if (kind == RSP_DATA) begin
      new_ctrl[LEN_W-1:0] = eff_len - 1'b1;
      new_ctrl[B_ACT]     = 1'b0;
      new_ctrl[B_NAK]     = 1'b0;
      if ((fields.cls == PC_IN) && ctrl[B_SPD] && (eff_len < fields.maxlen)) begin
        short_hit = 1'b1;
        code      = CODE_NOADV;
      end else begin
        code      = CODE_SUCCESS;
      end
    end else if (kind == RSP_STALL) begin
      new_ctrl[B_STALL] = 1'b1;
      new_ctrl[B_ACT]   = 1'b0;
    end else begin
      if (kind == RSP_NAK) new_ctrl[B_NAK] = 1'b1;
      if (timeout) begin
        new_ctrl[B_TMO]            = 1'b1;
        new_ctrl[B_ERRLO +: ERR_W] = cnt_next;
        if (cnt_done) begin
          new_ctrl[B_ACT] = 1'b0;
          bus_err         = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/td_outcome_updater.sv
module td_outcome_updater
  import td_pkg::*;
#(
  parameter int WORD_W = TD_WORD_W,
  parameter int LEN_W  = TD_LEN_W,
  parameter int ERR_W  = TD_ERR_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              td_valid,
  output logic              td_ready,
  input  logic [WORD_W-1:0] td_ctrl,
  input  logic [WORD_W-1:0] td_token,
  output logic              pkt_valid,
  output logic [7:0]        pkt_pid,
  output logic [6:0]        pkt_addr,
  output logic [3:0]        pkt_ep,
  output logic [LEN_W-1:0]  pkt_maxlen,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [2:0]        rsp_kind,
  input  logic [LEN_W:0]    rsp_len,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_ctrl,
  output logic [1:0]        res_code,
  output logic [1:0]        res_cause,
  output logic              res_perr,
  output logic              res_uerr
);
  typedef enum logic {S_IDLE, S_WAIT} st_e;

  logic rst_int_n;
  st_e  st_q, st_d;

  logic [WORD_W-1:0] ctrl_q, tok_q;
  logic              rv_q, rv_d;
  logic [WORD_W-1:0] rctrl_q, rctrl_d;
  logic [1:0]        rcode_q, rcode_d;
  logic [1:0]        rcause_q, rcause_d;
  logic              perr_q, perr_d, uerr_q, uerr_d;

  tok_fields_t       in_f, held_f;
  logic [WORD_W-1:0] calc_ctrl;
  logic [1:0]        calc_code;
  logic              calc_short, calc_uerr;
  logic              accept, rsp_hs;

  td_reset_sync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  td_token_decode #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_dec_in (
    .token  (td_token),
    .fields (in_f)
  );

  td_token_decode #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_dec_held (
    .token  (tok_q),
    .fields (held_f)
  );

  td_outcome_calc #(.WORD_W(WORD_W), .LEN_W(LEN_W), .ERR_W(ERR_W)) u_calc (
    .ctrl      (ctrl_q),
    .fields    (held_f),
    .kind      (rsp_kind),
    .rsp_len   (rsp_len),
    .new_ctrl  (calc_ctrl),
    .code      (calc_code),
    .short_hit (calc_short),
    .bus_err   (calc_uerr)
  );

  assign td_ready  = (st_q == S_IDLE) && rst_int_n;
  assign rsp_ready = (st_q == S_WAIT);
  assign pkt_valid = (st_q == S_WAIT);
  assign accept    = td_valid && td_ready;
  assign rsp_hs    = rsp_valid && rsp_ready;

  // next-state logic
  always_comb begin
    st_d     = st_q;
    rv_d     = 1'b0;
    rctrl_d  = rctrl_q;
    rcode_d  = rcode_q;
    rcause_d = rcause_q;
    perr_d   = 1'b0;
    uerr_d   = 1'b0;
    if (accept) begin
      rv_d    = 1'b1;
      rctrl_d = td_ctrl;
      if (!td_ctrl[B_ACT]) begin
        rcode_d  = CODE_NOADV;
        rcause_d = {1'b0, td_ctrl[B_IOC]};
      end else if (in_f.cls == PC_BAD) begin
        rcode_d  = CODE_ABORT;
        rcause_d = {1'b0, td_ctrl[B_IOC]};
        perr_d   = 1'b1;
      end else begin
        rcode_d  = CODE_PENDING;
        rcause_d = 2'b00;
        st_d     = S_WAIT;
      end
    end else if (rsp_hs) begin
      rv_d     = 1'b1;
      rctrl_d  = calc_ctrl;
      rcode_d  = calc_code;
      rcause_d = {calc_short, ctrl_q[B_IOC]};
      uerr_d   = calc_uerr;
      st_d     = S_IDLE;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q     <= S_IDLE;
      rv_q     <= 1'b0;
      perr_q   <= 1'b0;
      uerr_q   <= 1'b0;
      ctrl_q   <= '0;
      tok_q    <= '0;
      rctrl_q  <= '0;
      rcode_q  <= '0;
      rcause_q <= '0;
    end else begin
      st_q   <= st_d;
      rv_q   <= rv_d;
      perr_q <= perr_d;
      uerr_q <= uerr_d;
      if (accept) begin
        ctrl_q <= td_ctrl;
        tok_q  <= td_token;
      end
      if (rv_d) begin
        rctrl_q  <= rctrl_d;
        rcode_q  <= rcode_d;
        rcause_q <= rcause_d;
      end
    end
  end

  assign pkt_pid    = held_f.pid;
  assign pkt_addr   = held_f.addr;
  assign pkt_ep     = held_f.ep;
  assign pkt_maxlen = held_f.maxlen;
  assign res_valid  = rv_q;
  assign res_ctrl   = rctrl_q;
  assign res_code   = rcode_q;
  assign res_cause  = rcause_q;
  assign res_perr   = perr_q;
  assign res_uerr   = uerr_q;
endmodule

// File: rtl/td_outcome_checker.sv
module td_outcome_checker
  import td_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        td_valid,
  input logic        td_ready,
  input logic [31:0] td_ctrl,
  input logic [31:0] td_token,
  input logic        pkt_valid,
  input logic [7:0]  pkt_pid,
  input logic [10:0] pkt_maxlen,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        res_valid,
  input logic [31:0] res_ctrl,
  input logic [1:0]  res_code,
  input logic        res_perr,
  input logic        res_uerr
);
  logic legal_pid;
  assign legal_pid = (td_token[7:0] == PID_IN) || (td_token[7:0] == PID_OUT) ||
                     (td_token[7:0] == PID_SETUP);

  assert_handshake_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(td_ready && rsp_ready));

  assert_inactive_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (td_valid && td_ready && !td_ctrl[B_ACT]) |=>
      (res_valid && res_code == CODE_NOADV && res_ctrl == $past(td_ctrl) && td_ready));

  assert_pending_report_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (td_valid && td_ready && td_ctrl[B_ACT] && legal_pid) |=>
      (res_valid && res_code == CODE_PENDING && rsp_ready));

  assert_final_after_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> (res_valid && res_code != CODE_PENDING && td_ready));

  assert_fields_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && $past(pkt_valid)) |-> ($stable(pkt_pid) && $stable(pkt_maxlen)));

  assert_perr_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_perr |-> (res_valid && res_code == CODE_ABORT));

  assert_uerr_inactive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_uerr |-> (res_valid && !res_ctrl[B_ACT] && res_ctrl[B_TMO]));

  assert_abort_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == CODE_ABORT && !res_perr) |->
      (res_ctrl[B_BABBLE] && res_ctrl[B_STALL] && !res_ctrl[B_ACT]));
endmodule

bind td_outcome_updater td_outcome_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .td_valid   (td_valid),
  .td_ready   (td_ready),
  .td_ctrl    (td_ctrl),
  .td_token   (td_token),
  .pkt_valid  (pkt_valid),
  .pkt_pid    (pkt_pid),
  .pkt_maxlen (pkt_maxlen),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .res_valid  (res_valid),
  .res_ctrl   (res_ctrl),
  .res_code   (res_code),
  .res_perr   (res_perr),
  .res_uerr   (res_uerr)
);

// File: tb/td_outcome_updater_tb_top.sv
module td_outcome_updater_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        td_valid = 1'b0;
  logic        td_ready;
  logic [31:0] td_ctrl = '0;
  logic [31:0] td_token = '0;
  logic        pkt_valid;
  logic [7:0]  pkt_pid;
  logic [6:0]  pkt_addr;
  logic [3:0]  pkt_ep;
  logic [10:0] pkt_maxlen;
  logic        rsp_valid = 1'b0;
  logic        rsp_ready;
  logic [2:0]  rsp_kind = '0;
  logic [11:0] rsp_len = '0;
  logic        res_valid;
  logic [31:0] res_ctrl;
  logic [1:0]  res_code;
  logic [1:0]  res_cause;
  logic        res_perr;
  logic        res_uerr;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  td_outcome_updater dut_i (
    .clk(clk), .rst_n(rst_n),
    .td_valid(td_valid), .td_ready(td_ready), .td_ctrl(td_ctrl), .td_token(td_token),
    .pkt_valid(pkt_valid), .pkt_pid(pkt_pid), .pkt_addr(pkt_addr), .pkt_ep(pkt_ep),
    .pkt_maxlen(pkt_maxlen),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind), .rsp_len(rsp_len),
    .res_valid(res_valid), .res_ctrl(res_ctrl), .res_code(res_code), .res_cause(res_cause),
    .res_perr(res_perr), .res_uerr(res_uerr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // expected final outcome computed from the requirements
  function automatic void model(input logic [31:0] c, input logic [31:0] tok,
                                input int kind, input int len,
                                output logic [31:0] oc, output int code,
                                output int cause, output bit perr, output bit uerr,
                                output bit pend);
    int maxl, l, e;
    logic [7:0] pid;
    bit bab, tmo;
    maxl = (int'(tok[31:21]) + 1) & 'h7FF;
    pid  = tok[7:0];
    oc = c; cause = int'(c[24]); perr = 0; uerr = 0; pend = 0; code = 1;
    if (!c[23]) return;
    if (pid != 8'h69 && pid != 8'hE1 && pid != 8'h2D) begin code = 2; perr = 1; return; end
    pend = 1;
    if (c[25]) oc[23] = 1'b0;
    bab = (kind == 4) || (kind == 0 && pid == 8'h69 && len > maxl);
    tmo = (kind == 3) || (kind >= 5) || (kind == 1 && pid == 8'h2D);
    if (bab) begin
      oc[20] = 1'b1; oc[22] = 1'b1; oc[23] = 1'b0; code = 2;
    end else if (kind == 0) begin
      l = (pid == 8'h69) ? len : maxl;
      oc[10:0] = 11'((l - 1) & 'h7FF);
      oc[23] = 1'b0; oc[19] = 1'b0;
      if (pid == 8'h69 && c[29] && l < maxl) begin cause = cause | 2; code = 1; end
      else code = 0;
    end else if (kind == 2) begin
      oc[22] = 1'b1; oc[23] = 1'b0; code = 1;
    end else begin
      if (kind == 1) oc[19] = 1'b1;
      if (tmo) begin
        oc[18] = 1'b1;
        e = int'(c[28:27]);
        if (e != 0) begin
          e--;
          if (e == 0) begin oc[23] = 1'b0; uerr = 1; end
        end
        oc[28:27] = 2'(e);
      end
      code = 1;
    end
  endfunction

  task automatic run_td(input logic [31:0] c, input logic [31:0] tok,
                        input int kind, input int len, input int delay, input string req);
    logic [31:0] oc;
    int code, cause;
    bit perr, uerr, pend;
    model(c, tok, kind, len, oc, code, cause, perr, uerr, pend);
    @(negedge clk);
    chk(td_ready == 1'b1, req, "td_ready before offer", 32'(td_ready), 32'd1);
    td_valid = 1'b1; td_ctrl = c; td_token = tok;
    @(negedge clk);
    td_valid = 1'b0;
    if (pend) begin
      chk(res_valid && res_code == 2'd3 && res_ctrl == c && res_cause == 2'd0,
          "R5", "pending report", {res_valid, res_code, res_cause, 27'd0}, {1'b1, 2'd3, 2'd0, 27'd0});
      chk(pkt_valid && pkt_pid == tok[7:0] && pkt_addr == tok[14:8] && pkt_ep == tok[18:15] &&
          pkt_maxlen == 11'((int'(tok[31:21]) + 1) & 'h7FF), "R3", "packet fields",
          {pkt_pid, pkt_addr, pkt_ep, pkt_maxlen, 2'd0},
          {tok[7:0], tok[14:8], tok[18:15], 11'(tok[31:21] + 11'd1), 2'd0});
      for (int i = 0; i < delay; i++) begin
        @(negedge clk);
        chk(rsp_ready && !td_ready && !res_valid, "R5", "holding for response",
            {29'd0, rsp_ready, td_ready, res_valid}, 32'd4);
      end
      rsp_valid = 1'b1; rsp_kind = 3'(kind); rsp_len = 12'(len);
      @(negedge clk);
      rsp_valid = 1'b0;
    end else begin
      chk(!rsp_ready && !pkt_valid, "R2", "no response requested", {30'd0, rsp_ready, pkt_valid}, 32'd0);
    end
    chk(res_valid == 1'b1, req, "report valid", 32'(res_valid), 32'd1);
    chk(res_ctrl == oc, req, "control word", res_ctrl, oc);
    chk(int'(res_code) == code, req, "code", 32'(res_code), 32'(code));
    chk(int'(res_cause) == cause, {req, " R13"}, "cause", 32'(res_cause), 32'(cause));
    chk(res_perr == perr, "R4", "protocol error", 32'(res_perr), 32'(perr));
    chk(res_uerr == uerr, "R9", "bus error", 32'(res_uerr), 32'(uerr));
    @(negedge clk);
    chk(res_valid == 1'b0, req, "single report pulse", 32'(res_valid), 32'd0);
  endtask

  function automatic logic [31:0] mk_tok(input logic [10:0] mfield, input logic [3:0] ep,
                                         input logic [6:0] addr, input logic [7:0] pid);
    return {mfield, 2'b00, ep, addr, pid};
  endfunction

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(td_ready && !rsp_ready && !pkt_valid && !res_valid && !res_perr && !res_uerr, "R1", "reset state",
        {26'd0, td_ready, rsp_ready, pkt_valid, res_valid, res_perr, res_uerr}, 32'h20);

    // R2: inactive descriptor with completion interrupt
    run_td(32'h0100_0005, mk_tok(11'd7, 4'd1, 7'd3, 8'h69), 0, 3, 0, "R2");
    // R4: bad identifier
    run_td(32'h0180_0000, mk_tok(11'd7, 4'd1, 7'd3, 8'hA5), 0, 3, 0, "R4");
    // R6 + R3 + R5: OUT success with held-off response
    run_td(32'h0088_0000, mk_tok(11'd7, 4'd5, 7'h12, 8'hE1), 0, 0, 3, "R6");
    // R8: IN short packet with detection
    run_td(32'h2080_0000, mk_tok(11'd7, 4'd2, 7'd9, 8'h69), 0, 3, 1, "R8");
    // R8: IN exact length with detection
    run_td(32'h2180_0000, mk_tok(11'd7, 4'd2, 7'd9, 8'h69), 0, 8, 0, "R8");
    // R7: IN longer than maximum
    run_td(32'h0080_0000, mk_tok(11'd7, 4'd2, 7'd9, 8'h69), 0, 10, 0, "R7");
    // R7: babble response on OUT
    run_td(32'h0080_0000, mk_tok(11'd3, 4'd2, 7'd9, 8'hE1), 4, 0, 0, "R7");
    // R9: timeout with counter 1 exhausts
    run_td(32'h0880_0000, mk_tok(11'd7, 4'd0, 7'd1, 8'h69), 3, 0, 0, "R9");
    // R9: counter already zero
    run_td(32'h0080_0000, mk_tok(11'd7, 4'd0, 7'd1, 8'h69), 6, 0, 0, "R9");
    // R10: NAK on SETUP folds into timeout
    run_td(32'h1880_0000, mk_tok(11'd7, 4'd0, 7'd1, 8'h2D), 1, 0, 0, "R10");
    // R10: NAK on IN keeps active
    run_td(32'h1880_0000, mk_tok(11'd7, 4'd0, 7'd1, 8'h69), 1, 0, 0, "R10");
    // R11: stall
    run_td(32'h0080_0000, mk_tok(11'd7, 4'd0, 7'd1, 8'hE1), 2, 0, 2, "R11");
    // R12: isochronous select clears active on NAK
    run_td(32'h0280_0000, mk_tok(11'd7, 4'd0, 7'd1, 8'h69), 1, 0, 0, "R12");
    // R6: maximum field all ones encodes zero length
    run_td(32'h0080_0000, mk_tok(11'h7FF, 4'd0, 7'd1, 8'h69), 0, 0, 0, "R6");

    // constrained random
    for (int it = 0; it < 400; it++) begin
      logic [31:0] c, tok;
      logic [7:0] pid;
      int kind, len, ml, delay;
      c = $urandom;
      if (($urandom % 5) != 0) c[23] = 1'b1;
      case ($urandom % 4)
        0: pid = 8'h69;
        1: pid = 8'hE1;
        2: pid = 8'h2D;
        default: pid = 8'($urandom);
      endcase
      ml   = int'($urandom % 16);
      tok  = mk_tok(11'(ml), 4'($urandom), 7'($urandom), pid);
      kind = int'($urandom % 8);
      len  = int'($urandom % (ml + 4));
      delay = int'($urandom % 3);
      run_td(c, tok, kind, len, delay, "random R6..R12");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete, actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule